// File: doc/BRIEF.md
# Arc Event Discriminator

This block watches the sampled output voltage of a high-voltage supply and decides, for each accepted sample, whether the interval it closes holds a confirmed arc, a switching-noise transient, an ambiguous steep fall, or nothing of interest. The decision never rests on the voltage alone. A sample counts as a steep fall only when the drop from the previous sample is larger than a programmable slope limit. That steep fall is then sorted by a harmonic-distortion figure, which is computed outside the block and delivered with its own valid strobe.

A confirmed arc produces a one-cycle `arc_pulse`, and switching noise produces a one-cycle `noise_pulse`. An ambiguous fall produces no pulse and is only counted. Three saturating counters record the arc, noise and ambiguous events, and a synchronous clear input resets them. The slope limit and the two distortion limits sit in registers behind a small write port. Distortion is expressed in tenths of a percent, so the defaults 150 and 50 stand for 15 % and 5 %.

Top module: `arc_discriminator`

## Requirements
- R1: After reset `arc_pulse` and `noise_pulse` are low, and all three counters read zero. The thresholds hold their defaults: slope limit `DEF_SLOPE`, upper distortion limit `DEF_DIST_HI`, lower distortion limit `DEF_DIST_LO`.
- R2: After reset, the first sample accepted (`smp_valid` high) only loads the history register and never produces an event.
- R3: The fall of a sample is the previous sample minus the current sample. A sample is steep only when that fall is strictly greater than the slope limit. A rising or flat sample is never steep.
- R4: A steep sample whose latched distortion is strictly above the upper limit raises `arc_pulse` for exactly one cycle, in the cycle after the sample is accepted. In that same cycle `arc_count` goes up by one.
- R5: A steep sample whose latched distortion is strictly below the lower limit raises `noise_pulse` for one cycle and increments `noise_count`. It raises no arc pulse.
- R6: A steep sample whose distortion lies between the two limits, both limits included, raises no pulse and increments only `ambig_count`.
- R7: A sample that is not steep produces no event, whatever the distortion value.
- R8: Only the first steep sample in a run of steep samples is classified. Classification rearms only after one accepted sample that is not steep.
- R9: `dist_val` is latched when `dist_valid` is high. A sample accepted in the same cycle still uses the value held before the update.
- R10: A write with `cfg_we` high stores `cfg_wdata` at one of three addresses: 0 is the slope limit, 1 is the upper distortion limit, 2 is the lower distortion limit. A write to address 3 changes nothing. A sample accepted in the write cycle uses the old limits.
- R11: Each counter stops at its all-ones value and does not wrap.
- R12: `cnt_clear` zeroes all three counters at the next clock edge and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Voltage sample strobe |
| smp_volt | input | VW | Unsigned voltage sample code |
| dist_valid | input | 1 | Distortion update strobe |
| dist_val | input | DW | Distortion figure in 0.1 % units |
| cfg_we | input | 1 | Threshold write enable |
| cfg_addr | input | 2 | Threshold register select |
| cfg_wdata | input | CFG_DW | Threshold write data |
| cnt_clear | input | 1 | Synchronous counter clear |
| arc_pulse | output | 1 | One-cycle confirmed-arc flag |
| noise_pulse | output | 1 | One-cycle switching-noise flag |
| arc_count | output | CNT_W | Saturating arc event count |
| noise_count | output | CNT_W | Saturating noise event count |
| ambig_count | output | CNT_W | Saturating ambiguous event count |

## Verification
Directed falls of exactly the slope limit and of one code more separate the strict comparison from an inclusive one. Rising samples and gentle falls taken under high distortion show that the distortion figure alone never flags an arc. Runs of consecutive steep samples, first without and then with a gentle sample between them, show that the rearm rule gates classification. Distortion values just inside and just outside each limit tell the three classes apart. Long random voltage walks mix these cases with distortion updates, threshold writes to valid and invalid addresses, clears and counter saturation, and every result is compared against a bench model.

// File: rtl/arc_disc_pkg.sv
package arc_disc_pkg;
   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_ARC   = 2'd1,
      EV_NOISE = 2'd2,
      EV_AMBIG = 2'd3
   } ev_kind_e;

   localparam int unsigned N_EV_CNT   = 3;
   localparam int unsigned IDX_ARC    = 0;
   localparam int unsigned IDX_NOISE  = 1;
   localparam int unsigned IDX_AMBIG  = 2;

   localparam logic [1:0] ADDR_SLOPE   = 2'd0;
   localparam logic [1:0] ADDR_DIST_HI = 2'd1;
   localparam logic [1:0] ADDR_DIST_LO = 2'd2;
endpackage

// File: rtl/arc_cfg_regs.sv
module arc_cfg_regs
   import arc_disc_pkg::*;
#(
   parameter int unsigned CFG_DW      = 16,
   parameter int unsigned DEF_SLOPE   = 25,
   parameter int unsigned DEF_DIST_HI = 150,
   parameter int unsigned DEF_DIST_LO = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [CFG_DW-1:0] wdata,
   output logic [CFG_DW-1:0] slope_thr,
   output logic [CFG_DW-1:0] dist_hi,
   output logic [CFG_DW-1:0] dist_lo
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slope_thr <= CFG_DW'(DEF_SLOPE);
         dist_hi   <= CFG_DW'(DEF_DIST_HI);
         dist_lo   <= CFG_DW'(DEF_DIST_LO);
      end else if (we) begin
         case (addr)
            ADDR_SLOPE:   slope_thr <= wdata;
            ADDR_DIST_HI: dist_hi   <= wdata;
            ADDR_DIST_LO: dist_lo   <= wdata;
            default:      ;
         endcase
      end
   end
endmodule

// File: rtl/arc_slope.sv
module arc_slope #(
   parameter int unsigned VW     = 12,
   parameter int unsigned CFG_DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [VW-1:0]     smp_volt,
   input  logic [CFG_DW-1:0] slope_thr,
   output logic              judged,
   output logic              steep
);
   logic [VW-1:0] prev_q;
   logic          primed_q;
   logic [VW-1:0] fall;
   logic          falling;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
      end else if (smp_valid) begin
         prev_q   <= smp_volt;
         primed_q <= 1'b1;
      end
   end

   always_comb begin
      falling = smp_volt < prev_q;
      fall    = prev_q - smp_volt;
      judged  = smp_valid && primed_q;
      steep   = judged && falling && (CFG_DW'(fall) > slope_thr);
   end
endmodule

// File: rtl/arc_classify.sv
module arc_classify
   import arc_disc_pkg::*;
#(
   parameter int unsigned DW     = 10,
   parameter int unsigned CFG_DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dist_valid,
   input  logic [DW-1:0]     dist_val,
   input  logic [CFG_DW-1:0] dist_hi,
   input  logic [CFG_DW-1:0] dist_lo,
   input  logic              judged,
   input  logic              steep,
   output ev_kind_e          ev_kind,
   output logic              arc_pulse,
   output logic              noise_pulse
);
   logic [DW-1:0] dist_q;
   logic          armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dist_q <= '0;
      end else if (dist_valid) begin
         dist_q <= dist_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
      end else if (judged) begin
         armed_q <= !steep;
      end
   end

   always_comb begin
      ev_kind = EV_NONE;
      if (steep && armed_q) begin
         if (CFG_DW'(dist_q) > dist_hi)      ev_kind = EV_ARC;
         else if (CFG_DW'(dist_q) < dist_lo) ev_kind = EV_NOISE;
         else                                ev_kind = EV_AMBIG;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arc_pulse   <= 1'b0;
         noise_pulse <= 1'b0;
      end else begin
         arc_pulse   <= (ev_kind == EV_ARC);
         noise_pulse <= (ev_kind == EV_NOISE);
      end
   end
endmodule

// File: rtl/arc_sat_cnt.sv
module arc_sat_cnt #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (inc && (count != CNT_MAX)) begin
         count <= count + W'(1);
      end
   end
endmodule

// File: rtl/arc_discriminator.sv
module arc_discriminator
   import arc_disc_pkg::*;
#(
   parameter int unsigned VW          = 12,
   parameter int unsigned DW          = 10,
   parameter int unsigned CFG_DW      = 16,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned DEF_SLOPE   = 25,
   parameter int unsigned DEF_DIST_HI = 150,
   parameter int unsigned DEF_DIST_LO = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [VW-1:0]     smp_volt,
   input  logic              dist_valid,
   input  logic [DW-1:0]     dist_val,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   input  logic              cnt_clear,
   output logic              arc_pulse,
   output logic              noise_pulse,
   output logic [CNT_W-1:0]  arc_count,
   output logic [CNT_W-1:0]  noise_count,
   output logic [CNT_W-1:0]  ambig_count
);
   if (CFG_DW < VW || CFG_DW < DW) begin : g_bad_cfg_width
      $error("CFG_DW must cover VW and DW");
   end
   if (CNT_W < 2) begin : g_bad_cnt_width
      $error("CNT_W must be at least 2");
   end
   if (DEF_DIST_LO > DEF_DIST_HI) begin : g_bad_dist_def
      $error("DEF_DIST_LO must not exceed DEF_DIST_HI");
   end
   if (DEF_SLOPE >= (1 << VW)) begin : g_bad_slope_def
      $error("DEF_SLOPE exceeds the sample range");
   end

   logic [CFG_DW-1:0] slope_thr, dist_hi, dist_lo;
   logic              judged, steep;
   ev_kind_e          ev_kind;
   logic [N_EV_CNT-1:0] inc_vec;
   logic [CNT_W-1:0]    cnt_arr [N_EV_CNT];

   arc_cfg_regs #(
      .CFG_DW(CFG_DW), .DEF_SLOPE(DEF_SLOPE),
      .DEF_DIST_HI(DEF_DIST_HI), .DEF_DIST_LO(DEF_DIST_LO)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .slope_thr(slope_thr), .dist_hi(dist_hi), .dist_lo(dist_lo)
   );

   arc_slope #(.VW(VW), .CFG_DW(CFG_DW)) u_slope (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_volt(smp_volt),
      .slope_thr(slope_thr), .judged(judged), .steep(steep)
   );

   arc_classify #(.DW(DW), .CFG_DW(CFG_DW)) u_class (
      .clk(clk), .rst_n(rst_n), .dist_valid(dist_valid), .dist_val(dist_val),
      .dist_hi(dist_hi), .dist_lo(dist_lo), .judged(judged), .steep(steep),
      .ev_kind(ev_kind), .arc_pulse(arc_pulse), .noise_pulse(noise_pulse)
   );

   always_comb begin
      inc_vec            = '0;
      inc_vec[IDX_ARC]   = (ev_kind == EV_ARC);
      inc_vec[IDX_NOISE] = (ev_kind == EV_NOISE);
      inc_vec[IDX_AMBIG] = (ev_kind == EV_AMBIG);
   end

   for (genvar i = 0; i < N_EV_CNT; i++) begin : g_cnt
      arc_sat_cnt #(.W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .clr(cnt_clear), .inc(inc_vec[i]),
         .count(cnt_arr[i])
      );
   end

   assign arc_count   = cnt_arr[IDX_ARC];
   assign noise_count = cnt_arr[IDX_NOISE];
   assign ambig_count = cnt_arr[IDX_AMBIG];
endmodule

// File: rtl/arc_disc_chk.sv
module arc_disc_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_valid,
   input logic             cnt_clear,
   input logic             arc_pulse,
   input logic             noise_pulse,
   input logic [CNT_W-1:0] arc_count,
   input logic [CNT_W-1:0] noise_count,
   input logic [CNT_W-1:0] ambig_count
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   // R4: a pulse follows an accepted sample
   p_pulse_from_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (arc_pulse || noise_pulse) |-> $past(smp_valid));

   // R8: two arcs in a row would need two armed steep samples
   p_single_arc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      arc_pulse |=> !arc_pulse);

   // R5: noise and arc never flagged together
   p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(arc_pulse && noise_pulse));

   // R4: arc count follows the pulse
   p_arc_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (arc_pulse && !$past(cnt_clear) && $past(arc_count) != MAXV)
      |-> arc_count == $past(arc_count) + CNT_W'(1));

   // R11: saturated counters hold
   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (arc_count == MAXV && !cnt_clear) |=> arc_count == MAXV);
   p_noise_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (noise_count == MAXV && !cnt_clear) |=> noise_count == MAXV);

   // R12: clear zeroes every counter
   p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clear |=> (arc_count == '0 && noise_count == '0 && ambig_count == '0));
endmodule

bind arc_discriminator arc_disc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .cnt_clear(cnt_clear),
   .arc_pulse(arc_pulse), .noise_pulse(noise_pulse), .arc_count(arc_count),
   .noise_count(noise_count), .ambig_count(ambig_count)
);

// File: tb/arc_discriminator_test.sv
`timescale 1ns/1ps
module arc_discriminator_test;
   localparam int unsigned VW = 12, DW = 10, CFG_DW = 16, CNT_W = 8;
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic smp_valid = 1'b0, dist_valid = 1'b0, cfg_we = 1'b0, cnt_clear = 1'b0;
   logic [VW-1:0] smp_volt = '0;
   logic [DW-1:0] dist_val = '0;
   logic [1:0] cfg_addr = '0;
   logic [CFG_DW-1:0] cfg_wdata = '0;
   logic arc_pulse, noise_pulse;
   logic [CNT_W-1:0] arc_count, noise_count, ambig_count;

   int errors = 0, checks = 0;

   always #2.5 clk = ~clk;

   arc_discriminator #(.VW(VW), .DW(DW), .CFG_DW(CFG_DW), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_volt(smp_volt),
      .dist_valid(dist_valid), .dist_val(dist_val), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cnt_clear(cnt_clear),
      .arc_pulse(arc_pulse), .noise_pulse(noise_pulse), .arc_count(arc_count),
      .noise_count(noise_count), .ambig_count(ambig_count)
   );

   // bench model, written from the requirements
   logic [VW-1:0] m_prev;
   logic m_primed, m_armed, e_arc, e_noise;
   logic [DW-1:0] m_dist;
   int unsigned m_slope, m_hi, m_lo;
   logic [CNT_W-1:0] m_arc, m_noise, m_amb;

   function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] c, logic inc, logic clr);
      if (clr) return '0;
      if (inc && c != CMAX) return c + 1'b1;
      return c;
   endfunction

   task automatic model_reset();
      m_prev = '0; m_primed = 0; m_armed = 1; m_dist = '0;
      m_slope = 25; m_hi = 150; m_lo = 50;
      m_arc = '0; m_noise = '0; m_amb = '0; e_arc = 0; e_noise = 0;
   endtask

   task automatic chk(string tag, int unsigned act, int unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(logic sv, logic [VW-1:0] v, logic dv, logic [DW-1:0] d,
                       logic we, logic [1:0] a, logic [CFG_DW-1:0] wd, logic clr);
      logic judged, steep, ev, ea, en, eb;
      smp_valid = sv; smp_volt = v; dist_valid = dv; dist_val = d;
      cfg_we = we; cfg_addr = a; cfg_wdata = wd; cnt_clear = clr;
      judged = sv && m_primed;
      steep  = judged && (v < m_prev) && (int'(m_prev - v) > int'(m_slope));
      ev = steep && m_armed;
      ea = ev && (int'(m_dist) > int'(m_hi));
      en = ev && !ea && (int'(m_dist) < int'(m_lo));
      eb = ev && !ea && !en;
      e_arc = ea; e_noise = en;
      m_arc = sat_inc(m_arc, ea, clr);
      m_noise = sat_inc(m_noise, en, clr);
      m_amb = sat_inc(m_amb, eb, clr);
      if (judged) m_armed = !steep;
      if (sv) begin m_prev = v; m_primed = 1; end
      if (dv) m_dist = d;
      if (we) begin
         if (a == 2'd0) m_slope = wd;
         else if (a == 2'd1) m_hi = wd;
         else if (a == 2'd2) m_lo = wd;
      end
      @(negedge clk);
      chk("R4 arc_pulse", arc_pulse, e_arc);
      chk("R5 noise_pulse", noise_pulse, e_noise);
      chk("R4 arc_count", arc_count, m_arc);
      chk("R5 noise_count", noise_count, m_noise);
      chk("R6 ambig_count", ambig_count, m_amb);
   endtask

   task automatic smp(logic [VW-1:0] v);
      step(1, v, 0, '0, 0, 2'd0, '0, 0);
   endtask
   task automatic setd(logic [DW-1:0] d);
      step(0, '0, 1, d, 0, 2'd0, '0, 0);
   endtask
   task automatic wcfg(logic [1:0] a, logic [CFG_DW-1:0] wd);
      step(0, '0, 0, '0, 1, a, wd, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int unsigned v;
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 arc_pulse", arc_pulse, 0);
      chk("R1 noise_pulse", noise_pulse, 0);
      chk("R1 counters", arc_count + noise_count + ambig_count, 0);

      setd(10'd200);
      smp(12'd4000);                          // R2 prime only
      chk("R2 prime", arc_count, 0);
      smp(12'd3975);                          // R3 fall == limit
      chk("R3 equal fall", arc_pulse, 0);
      smp(12'd3949);                          // R3 fall 26 > 25
      chk("R3 R4 arc", arc_count, 1);
      smp(12'd3900);                          // R8 disarmed
      chk("R8 no rearm", arc_count, 1);
      smp(12'd3900);
      smp(12'd3800);                          // R8 rearmed
      chk("R8 rearm arc", arc_count, 2);
      smp(12'd4095);                          // R7 rise, high distortion
      smp(12'd4090);                          // R7 gentle fall
      chk("R7 no event", arc_count, 2);
      setd(10'd30);
      smp(12'd4000);                          // R5 noise
      chk("R5 noise", noise_count, 1);
      smp(12'd4000);
      setd(10'd150);
      smp(12'd3900);                          // R6 at upper limit
      chk("R6 ambig hi edge", ambig_count, 1);
      smp(12'd3900);
      setd(10'd50);
      smp(12'd3800);                          // R6 at lower limit
      chk("R6 ambig lo edge", ambig_count, 2);
      smp(12'd3800);
      step(1, 12'd3700, 1, 10'd20, 0, 2'd0, '0, 0);  // R9 old value used
      chk("R9 old dist", ambig_count, 3);
      smp(12'd3700);
      smp(12'd3600);
      chk("R9 new dist", noise_count, 2);
      smp(12'd3600);
      wcfg(2'd3, 16'd0);                      // R10 ignored address
      smp(12'd3580);
      chk("R10 bad addr", noise_count, 2);
      step(1, 12'd3560, 0, '0, 1, 2'd0, 16'd10, 0);  // R10 old limit this cycle
      chk("R10 old limit", noise_count, 2);
      smp(12'd3540);
      chk("R10 new limit", noise_count, 3);
      smp(12'd3540);
      wcfg(2'd2, 16'd0); wcfg(2'd1, 16'd10);
      smp(12'd3500);                          // dist 20 > hi 10
      chk("R10 dist limits", arc_count, 3);
      smp(12'd3500);
      step(1, 12'd3400, 0, '0, 0, 2'd0, '0, 1);      // R12 clear wins
      chk("R12 clear", arc_count, 0);
      for (int i = 0; i < 300; i++) begin
         smp(12'd3000); smp(12'd2900);
      end
      chk("R11 saturate", arc_count, CMAX);

      v = 2000;
      for (int i = 0; i < 4000; i++) begin
         logic sv, dv, we, clr;
         int d;
         sv = ($urandom % 4) != 0;
         d = int'($urandom % 90) - 60;
         if (int'(v) + d < 0) v = 0;
         else if (int'(v) + d > 4095) v = 4095;
         else v = v + d;
         dv = ($urandom % 8) == 0;
         we = ($urandom % 60) == 0;
         clr = ($urandom % 250) == 0;
         step(sv, v[VW-1:0], dv, 10'($urandom % 250), we, 2'($urandom % 4),
              16'($urandom % 200), clr);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule